// File: doc/BRIEF.md
# Tandem Crosspoint Cell Switch Core

This block is the switching core of a small square cell switch with N inputs and N outputs. Every input/output pair owns a crosspoint that can buffer exactly one cell. That buffer is shared by K logical switch planes placed one after another. Each cell slot is one clock cycle. In every slot, each plane runs its own round-robin arbiter for each output. The arbiter picks one of the crosspoints of that output whose cell currently sits on that plane.

An input controller offers a cell by raising its launch valid with a destination output and the cell data. If the addressed crosspoint is busy, the core refuses the cell with a not-acknowledge in the same cycle, and the cell stays in the input controller. An accepted cell first bids on plane 1 in the following slot. When it loses, it steps to the next plane for the next slot, wrapping from plane K back to plane 1. A granted cell leaves on the delivery lane of its plane, so an output can take in up to K cells per slot without any internal speedup. Because a crosspoint holds only one cell, cells from one input to one output are never reordered.

Top module: `tdx_fabric`

## Requirements
- R1: A crosspoint holds at most one cell. A launch aimed at a busy crosspoint raises that input's not-acknowledge in the same cycle and leaves the buffered cell unchanged. A launch aimed at a free crosspoint is accepted with no not-acknowledge.
- R2: A cell accepted in slot t first bids on plane 1 in slot t+1.
- R3: On each plane, each output grants at most one crosspoint per slot, and only one that is bidding on that plane.
- R4: A cell that loses on plane k bids on plane k+1 in the next slot. A cell that loses on plane K bids on plane 1 again and competes there with newly accepted cells.
- R5: Each plane/output arbiter searches upward from its ring pointer, wrapping from N-1 to 0. After a grant, the pointer moves to the input just above the winner. All pointers start at input 0.
- R6: Output o has K delivery lanes, and lane o*K+k (k counted from 0) carries the cell granted on plane k+1. Its data is the data of the winning input's cell. Up to K lanes of one output can be valid in the same slot.
- R7: A crosspoint becomes free at the end of the slot in which its cell is granted, and it can accept a new cell in the next slot.
- R8: Reset empties every crosspoint and clears all delivery lanes and not-acknowledges. This also holds when reset is applied while cells are buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cell slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_vld | input | N_PORTS | Per-input cell offer |
| launch_dst | input | N_PORTS*clog2(N_PORTS) | Destination output per input, input i at bits i*DW |
| launch_data | input | N_PORTS*CELL_W | Cell data per input, input i at bits i*CELL_W |
| launch_nack | output | N_PORTS | Refusal of the offered cell because the crosspoint is busy |
| out_vld | output | N_PORTS*K_PLANES | Delivery lane valid, lane o*K+k for plane k+1 of output o |
| out_data | output | N_PORTS*K_PLANES*CELL_W | Delivery lane data, same lane order |

## Verification
The bench builds the core with five ports, three planes and 8-bit cells. Five inputs are enough to make three cells bid for one output across staggered slots, so that all three lanes of that output are valid at once. Three planes exercise both a mid-chain step and the wrap from plane 3 back to plane 1. Odd port and plane counts also make every ring pointer and plane index wrap at a value that is not a power of two.

// File: rtl/tdx_pkg.sv
package tdx_pkg;

  // Next position on a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    if (idx + 1 >= n) return 0;
    return idx + 1;
  endfunction

  // Index in the ring reached from base after off steps.
  function automatic int unsigned ring_offset(input int unsigned base, input int unsigned off,
                                              input int unsigned n);
    int unsigned s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/tdx_rr_arb.sv
module tdx_rr_arb #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt
);
  import tdx_pkg::*;

  localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win_idx;
  logic          win_found;

  always_comb begin
    gnt       = '0;
    win_idx   = '0;
    win_found = 1'b0;
    for (int unsigned off = 0; off < N_REQ; off++) begin
      int unsigned cand;
      cand = ring_offset(int'(ptr_q), off, N_REQ);
      if (!win_found && req[cand]) begin
        gnt[cand] = 1'b1;
        win_idx   = IW'(cand);
        win_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (win_found) ptr_q <= IW'(ring_next(int'(win_idx), N_REQ));
  end

  // R3: at most one grant per slot on this plane/output
  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R3: a grant only goes to a bidding crosspoint
  p_grant_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  // R5: a pending request is never left without a grant
  p_no_idle_r5: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|gnt));

endmodule

// File: rtl/tdx_xpoint.sv
module tdx_xpoint #(
  parameter int unsigned K_PLANES = 3,
  parameter int unsigned CELL_W   = 16,
  localparam int unsigned PW      = (K_PLANES > 1) ? $clog2(K_PLANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_i,
  input  logic [CELL_W-1:0] offer_data_i,
  input  logic              grant_i,
  output logic              refuse_o,
  output logic              busy_o,
  output logic [PW-1:0]     plane_o,
  output logic [CELL_W-1:0] data_o
);
  import tdx_pkg::*;

  logic take;

  assign take     = offer_i && !busy_o;
  assign refuse_o = offer_i && busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      plane_o <= '0;
      data_o  <= '0;
    end else if (busy_o) begin
      if (grant_i) busy_o <= 1'b0;
      else plane_o <= PW'(ring_next(int'(plane_o), K_PLANES));
    end else if (take) begin
      busy_o  <= 1'b1;
      plane_o <= '0;
      data_o  <= offer_data_i;
    end
  end

  // R2: an accepted cell starts on plane 1
  p_load_plane1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_o && plane_o == '0);
  // R1: a buffered, ungranted cell keeps its data whatever is offered
  p_hold_cell_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !grant_i |=> busy_o && $stable(data_o));
  // R4: a losing cell changes plane every slot
  p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (K_PLANES > 1) && busy_o && !grant_i |=> plane_o != $past(plane_o));
  // R4: plane index stays inside the chain
  p_plane_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> int'(plane_o) < K_PLANES);
  // R7: a granted cell frees the buffer at the end of the slot
  p_free_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> !busy_o);
  // R3: no grant reaches an empty crosspoint
  p_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> busy_o);

endmodule

// File: rtl/tdx_lane_sel.sv
module tdx_lane_sel #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned CELL_W = 16
) (
  input  logic [N_SRC-1:0]        gnt,
  input  logic [N_SRC*CELL_W-1:0] src_data,
  output logic                    vld_o,
  output logic [CELL_W-1:0]       data_o
);
  always_comb begin
    data_o = '0;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      if (gnt[i]) data_o = data_o | src_data[i*CELL_W +: CELL_W];
    end
  end

  assign vld_o = |gnt;

  // R6: a valid lane comes from exactly one source
  always_comb begin
    if (vld_o) a_lane_single_r6: assert ($onehot(gnt));
  end

endmodule

// File: rtl/tdx_fabric.sv
module tdx_fabric #(
  parameter int unsigned N_PORTS  = 4,
  parameter int unsigned K_PLANES = 3,
  parameter int unsigned CELL_W   = 16,
  localparam int unsigned DW      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned PW      = (K_PLANES > 1) ? $clog2(K_PLANES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_PORTS-1:0]              launch_vld,
  input  logic [N_PORTS*DW-1:0]           launch_dst,
  input  logic [N_PORTS*CELL_W-1:0]       launch_data,
  output logic [N_PORTS-1:0]              launch_nack,
  output logic [N_PORTS*K_PLANES-1:0]     out_vld,
  output logic [N_PORTS*K_PLANES*CELL_W-1:0] out_data
);
  localparam int unsigned NXP = N_PORTS * N_PORTS;
  localparam int unsigned NLN = N_PORTS * K_PLANES;

  // Crosspoint (i,o) lives at index i*N_PORTS+o.
  logic [NXP-1:0]        xp_offer;
  logic [NXP-1:0]        xp_refuse;
  logic [NXP-1:0]        xp_busy;
  logic [NXP-1:0]        xp_grant;
  logic [NXP*PW-1:0]     xp_plane;
  logic [NXP*CELL_W-1:0] xp_data;
  // Lane (o,k) grant vector over inputs at (o*K_PLANES+k)*N_PORTS.
  logic [NLN*N_PORTS-1:0] lane_gnt;
  logic [NLN*N_PORTS-1:0] lane_req;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    for (genvar go = 0; go < N_PORTS; go++) begin : g_out
      localparam int unsigned X = gi * N_PORTS + go;
      logic [K_PLANES-1:0] hit;

      assign xp_offer[X] = launch_vld[gi] && (launch_dst[gi*DW +: DW] == DW'(go));
      for (genvar gk = 0; gk < K_PLANES; gk++) begin : g_hit
        assign hit[gk] = lane_gnt[(go*K_PLANES+gk)*N_PORTS + gi];
      end
      assign xp_grant[X] = |hit;

      tdx_xpoint #(.K_PLANES(K_PLANES), .CELL_W(CELL_W)) u_xp (
        .clk          (clk),
        .rst_n        (rst_n),
        .offer_i      (xp_offer[X]),
        .offer_data_i (launch_data[gi*CELL_W +: CELL_W]),
        .grant_i      (xp_grant[X]),
        .refuse_o     (xp_refuse[X]),
        .busy_o       (xp_busy[X]),
        .plane_o      (xp_plane[X*PW +: PW]),
        .data_o       (xp_data[X*CELL_W +: CELL_W])
      );
    end
  end

  for (genvar go = 0; go < N_PORTS; go++) begin : g_dst
    logic [N_PORTS*CELL_W-1:0] col_data;
    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_col
      assign col_data[gi*CELL_W +: CELL_W] = xp_data[(gi*N_PORTS+go)*CELL_W +: CELL_W];
    end
    for (genvar gk = 0; gk < K_PLANES; gk++) begin : g_pl
      localparam int unsigned L = go * K_PLANES + gk;
      for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_req
        assign lane_req[L*N_PORTS + gi] = xp_busy[gi*N_PORTS+go]
          && (xp_plane[(gi*N_PORTS+go)*PW +: PW] == PW'(gk));
      end

      tdx_rr_arb #(.N_REQ(N_PORTS)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lane_req[L*N_PORTS +: N_PORTS]),
        .gnt   (lane_gnt[L*N_PORTS +: N_PORTS])
      );

      tdx_lane_sel #(.N_SRC(N_PORTS), .CELL_W(CELL_W)) u_sel (
        .gnt      (lane_gnt[L*N_PORTS +: N_PORTS]),
        .src_data (col_data),
        .vld_o    (out_vld[L]),
        .data_o   (out_data[L*CELL_W +: CELL_W])
      );
    end
  end

  always_comb begin
    launch_nack = '0;
    for (int unsigned i = 0; i < N_PORTS; i++) begin
      launch_nack[i] = |xp_refuse[i*N_PORTS +: N_PORTS];
    end
  end

  // R1: a refusal only answers an actual offer
  p_nack_needs_offer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_nack & ~launch_vld) == '0);
  // R8: nothing is delivered in the first slot after reset
  p_quiet_after_reset_r8: assert property (@(posedge clk) $rose(rst_n) |-> out_vld == '0);

endmodule

// File: tb/sim_tdx_fabric.sv
`timescale 1ns/1ps
module sim_tdx_fabric;
  localparam int unsigned N  = 5;
  localparam int unsigned K  = 3;
  localparam int unsigned W  = 8;
  localparam int unsigned DW = 3;

  typedef struct packed {
    logic [N-1:0]    lv;
    logic [N*DW-1:0] dst;
    logic [N-1:0]    nack;
    logic [N*K-1:0]  vld;
    logic [3*3-1:0]  src;   // {lane2, lane1, lane0} source input of output 0
  } row_t;

  // Hand-worked slot sequence; src fields only read for valid output-0 lanes.
  localparam row_t TBL [12] = '{
    '{5'b01111, 15'd0,                               5'b00000, 15'b000000000000000, 9'd0},
    '{5'b00011, {3'd0,3'd0,3'd0,3'd1,3'd0},           5'b00001, 15'b000000000000001, {3'd0,3'd0,3'd0}},
    '{5'b00001, 15'd0,                               5'b00000, 15'b000000000001010, {3'd0,3'd1,3'd0}},
    '{5'b00010, 15'd0,                               5'b00000, 15'b000000000000101, {3'd2,3'd0,3'd0}},
    '{5'b01100, 15'd0,                               5'b01000, 15'b000000000000001, {3'd0,3'd0,3'd1}},
    '{5'b00000, 15'd0,                               5'b00000, 15'b000000000000011, {3'd0,3'd3,3'd2}},
    '{5'b11001, 15'd0,                               5'b00000, 15'b000000000000000, 9'd0},
    '{5'b00110, 15'd0,                               5'b00000, 15'b000000000000001, {3'd0,3'd0,3'd3}},
    '{5'b01000, 15'd0,                               5'b00000, 15'b000000000000011, {3'd0,3'd4,3'd1}},
    '{5'b00010, {3'd0,3'd0,3'd0,3'd4,3'd0},           5'b00000, 15'b000000000000111, {3'd0,3'd2,3'd3}},
    '{5'b00000, 15'd0,                               5'b00000, 15'b001000000000000, 9'd0},
    '{5'b00000, 15'd0,                               5'b00000, 15'b000000000000000, 9'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      launch_vld = '0;
  logic [N*DW-1:0]   launch_dst = '0;
  logic [N*W-1:0]    launch_data = '0;
  logic [N-1:0]      launch_nack;
  logic [N*K-1:0]    out_vld;
  logic [N*K*W-1:0]  out_data;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tdx_fabric #(.N_PORTS(N), .K_PLANES(K), .CELL_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .launch_vld(launch_vld), .launch_dst(launch_dst),
    .launch_data(launch_data), .launch_nack(launch_nack), .out_vld(out_vld),
    .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] tag_data(input int unsigned src);
    return {5'b10101, 3'(src)};
  endfunction

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) launch_data[i*W +: W] = tag_data(i);
    // R8: reset state, even with every input offering a cell
    launch_vld = '1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R8 reset lanes", 64'(out_vld), 64'd0);
    chk("R8 reset nack", 64'(launch_nack), 64'd0);
    launch_vld = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int r = 0; r < 12; r++) begin
      @(negedge clk);
      launch_vld = TBL[r].lv;
      launch_dst = TBL[r].dst;
      #1;
      chk($sformatf("R1 R7 nack row %0d", r), 64'(launch_nack), 64'(TBL[r].nack));
      chk($sformatf("R2 R3 R4 R5 lanes row %0d", r), 64'(out_vld), 64'(TBL[r].vld));
      for (int k = 0; k < K; k++) begin
        if (TBL[r].vld[k])
          chk($sformatf("R6 lane %0d data row %0d", k, r), 64'(out_data[k*W +: W]),
              64'(tag_data(TBL[r].src[k*3 +: 3])));
      end
    end

    // R8: reset while cells are buffered
    @(negedge clk);
    launch_vld = 5'b00011;
    launch_dst = {3'd0, 3'd0, 3'd0, 3'd3, 3'd3};
    @(negedge clk);
    launch_vld = '0;
    rst_n = 1'b0;
    #1;
    chk("R8 mid reset lanes", 64'(out_vld), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 empty after reset", 64'(out_vld), 64'd0);

    // R1: refused offer must not replace the waiting cell
    @(negedge clk);
    launch_vld = 5'b00011;
    launch_dst = {3'd0, 3'd0, 3'd0, 3'd2, 3'd2};
    launch_data[0 +: W] = 8'h11;
    launch_data[W +: W] = 8'h22;
    @(negedge clk);
    launch_vld = 5'b00010;
    launch_data[W +: W] = 8'hEE;
    #1;
    chk("R1 busy refuses", 64'(launch_nack), 64'b00010);
    chk("R5 first winner lane", 64'(out_vld), 64'(15'b000000001000000));
    chk("R6 first winner data", 64'(out_data[6*W +: W]), 64'h11);
    @(negedge clk);
    launch_vld = '0;
    #1;
    chk("R4 loser on plane 2", 64'(out_vld), 64'(15'b000000010000000));
    chk("R1 kept cell data", 64'(out_data[7*W +: W]), 64'h22);
    @(negedge clk); #1;
    chk("R7 all drained", 64'(out_vld), 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule